// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events raised by on-chip sources, packs each event into a 16-byte vector and stores the vector as four 32-bit words in a circular buffer held in system memory. A host reads the vectors back in order. The host and the block share two byte pointers. The block owns the write pointer and moves it forward after each stored vector. The host owns the read pointer and moves it forward as it consumes vectors. The ring holds no pending work when the two pointers are equal. An interrupt line stays high while unread vectors remain.

The ring sits at a 256-byte-aligned 40-bit address. Its length is programmed as a power of two in 32-bit words, and both pointers wrap at that length. If a vector fills the last free slot, the block sets a sticky overflow flag in the write-pointer value and keeps writing, so the oldest entries are overwritten. Software clears the flag through the control register. When writeback is enabled, the block copies the write-pointer value, flag included, to a second programmable 40-bit address after every vector. The host can move the read pointer with a register write or with a doorbell pulse. Disabling the ring clears both enables and both pointers.

The sequencer has six states. From IDLE, an accepted event goes to WORD0. WORD0, WORD1 and WORD2 each step to the next word when memory accepts the current word. WORD3 goes to WRITEBACK when writeback is enabled, and to IDLE otherwise. WRITEBACK returns to IDLE once accepted. A disabling control write sends any state to IDLE.

Top module: `ivr_writer`

## Requirements
- R1: After reset, ev_ready, mem_valid and irq are low, and the control, read-pointer and write-pointer registers read zero.
- R2: A vector is written as four words at ring base×256 + write pointer + 0, 4, 8 and 12. Word 0 holds the source in bits 7:0. Word 1 holds the source data in bits 27:0. Word 2 holds the ring tag in 7:0, the VM tag in 15:8 and the PASID in 31:16. Word 3 is zero.
- R3: The write pointer (register offset 3, bits PTR_W-1:0) advances by 16 once word 3 is accepted. It wraps at ring length 4·2^size bytes, where size is control bits 12:8.
- R4: If the advanced write pointer equals the read pointer, write-pointer bit 31 becomes set. The vector is still written and the pointer still advances, and the flag stays set across later vectors.
- R5: A control write (offset 0) with bit 31 set clears the overflow flag. Control bit 31 is not stored and reads zero.
- R6: With control bit 2 set, one extra word follows word 3. It goes to {WB_HI[7:0], WB_LO} (offsets 5 and 4) and carries the new write-pointer value with overflow in bit 31. With bit 2 clear, no such word is written.
- R7: A control write with bit 0 clear clears the ring enable and the interrupt enable (bit 1), resets both pointers and the overflow flag to zero, and aborts any vector in progress.
- R8: The read pointer (offset 2) is loaded by a register write or by a doorbell pulse. The value is masked to the ring length and to 16-byte alignment. A register write wins over a doorbell in the same cycle.
- R9: irq is high exactly when ring enable and interrupt enable are set and either the pointers differ or the overflow flag is set.
- R10: Control bit 16 reads one while a vector is in flight or an enabled event waits, and zero otherwise.
- R11: While mem_valid is high and mem_ready low, mem_addr and mem_data hold their values.
- R12: An event is accepted only in IDLE with the ring enabled. While the ring is disabled, ev_ready stays low and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken this cycle when valid |
| ev_src | input | 8 | Source identifier |
| ev_data | input | 28 | Source-specific data |
| ev_ring | input | 8 | Ring tag |
| ev_vm | input | 8 | VM tag |
| ev_pasid | input | 16 | Process address-space tag |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW (40) | Byte address of the word |
| mem_data | output | 32 | Word to write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0 control, 1 base, 2 read pointer, 3 write pointer, 4 writeback low, 5 writeback high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| db_valid | input | 1 | Doorbell pulse carrying a new read pointer |
| db_data | input | 32 | Doorbell value |
| irq | output | 1 | Unread vectors pending |

## Verification
The bench aims at the wrap from the last slot back to offset zero. A design that masks with the wrong length would write past the ring end, and the scoreboard would see wrong addresses. It fills the ring until the write pointer lands on the read pointer. A design that tests fullness one slot early or late would set bit 31 on the wrong vector or drop the interrupt when the pointers meet. It also checks that the flag survives further vectors and clears only on the control write. With writeback disabled, any stray fifth word counts as an unexpected write. A disable must zero both pointers and block events, even with an event held valid. Random back-pressure on the memory port exposes a sequencer that changes address or data while it waits.

// File: rtl/ivr_pkg.sv
`timescale 1ns/1ps
package ivr_pkg;
    localparam int WORD_W    = 32;
    localparam int VEC_BYTES = 16;
    localparam int SZ_W      = 5;
    localparam int RA_W      = 3;

    localparam logic [RA_W-1:0] REG_CTRL = 3'd0;
    localparam logic [RA_W-1:0] REG_BASE = 3'd1;
    localparam logic [RA_W-1:0] REG_RPTR = 3'd2;
    localparam logic [RA_W-1:0] REG_WPTR = 3'd3;
    localparam logic [RA_W-1:0] REG_WBLO = 3'd4;
    localparam logic [RA_W-1:0] REG_WBHI = 3'd5;

    localparam int CB_RING_EN = 0;
    localparam int CB_IRQ_EN  = 1;
    localparam int CB_WB_EN   = 2;
    localparam int CB_SIZE_LO = 8;
    localparam int CB_BUSY    = 16;
    localparam int CB_OVF     = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WORD0,
        ST_WORD1,
        ST_WORD2,
        ST_WORD3,
        ST_WRITEBACK
    } seq_state_t;

    typedef struct packed {
        logic [15:0] pasid;
        logic [7:0]  vm;
        logic [7:0]  ring;
        logic [27:0] data;
        logic [7:0]  src;
    } ivec_t;
endpackage

// File: rtl/ivr_regs.sv
`timescale 1ns/1ps
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18,
    parameter int AW    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              db_valid,
    input  logic [PTR_W-1:0]  db_ptr,
    input  logic [PTR_W-1:0]  wptr,
    input  logic              ovf,
    input  logic              busy,
    output logic              ring_en,
    output logic              irq_en,
    output logic              wb_en,
    output logic [PTR_W-1:0]  ptr_mask,
    output logic [PTR_W-1:0]  rptr,
    output logic [AW-9:0]     base,
    output logic [AW-1:0]     wb_addr,
    output logic              clr_ptrs,
    output logic              ovf_clr
);
    localparam int HI_W = AW - WORD_W;

    logic [SZ_W-1:0]   size_q;
    logic [WORD_W-1:0] wblo_q;
    logic [HI_W-1:0]   wbhi_q;
    logic [PTR_W:0]    span;
    logic wr_ctrl, wr_base, wr_rptr, wr_wblo, wr_wbhi;

    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_base = reg_wr && (reg_addr == REG_BASE);
    assign wr_rptr = reg_wr && (reg_addr == REG_RPTR);
    assign wr_wblo = reg_wr && (reg_addr == REG_WBLO);
    assign wr_wbhi = reg_wr && (reg_addr == REG_WBHI);

    assign clr_ptrs = wr_ctrl && !reg_wdata[CB_RING_EN];
    assign ovf_clr  = wr_ctrl && reg_wdata[CB_OVF];

    // ring length in bytes is 4 * 2^size; pointers stay 16-byte aligned
    assign span     = (PTR_W+1)'(1) << ({1'b0, size_q} + 6'd2);
    assign ptr_mask = (span[PTR_W-1:0] - PTR_W'(1)) & ~PTR_W'(VEC_BYTES - 1);
    assign wb_addr  = {wbhi_q, wblo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_en <= 1'b0;
            irq_en  <= 1'b0;
            wb_en   <= 1'b0;
            size_q  <= '0;
        end else if (wr_ctrl) begin
            ring_en <= reg_wdata[CB_RING_EN];
            irq_en  <= reg_wdata[CB_RING_EN] & reg_wdata[CB_IRQ_EN];
            wb_en   <= reg_wdata[CB_WB_EN];
            size_q  <= reg_wdata[CB_SIZE_LO +: SZ_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base   <= '0;
            wblo_q <= '0;
            wbhi_q <= '0;
        end else begin
            if (wr_base) base   <= reg_wdata[AW-9:0];
            if (wr_wblo) wblo_q <= reg_wdata;
            if (wr_wbhi) wbhi_q <= reg_wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rptr <= '0;
        else if (clr_ptrs) rptr <= '0;
        else if (wr_rptr)  rptr <= reg_wdata[PTR_W-1:0] & ptr_mask;
        else if (db_valid) rptr <= db_ptr & ptr_mask;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CB_RING_EN]             = ring_en;
                reg_rdata[CB_IRQ_EN]              = irq_en;
                reg_rdata[CB_WB_EN]               = wb_en;
                reg_rdata[CB_SIZE_LO +: SZ_W]     = size_q;
                reg_rdata[CB_BUSY]                = busy;
            end
            REG_BASE: reg_rdata[AW-9:0] = base;
            REG_RPTR: reg_rdata[PTR_W-1:0] = rptr;
            REG_WPTR: begin
                reg_rdata[PTR_W-1:0] = wptr;
                reg_rdata[CB_OVF]    = ovf;
            end
            REG_WBLO: reg_rdata = wblo_q;
            REG_WBHI: reg_rdata[HI_W-1:0] = wbhi_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R7: a disabling write leaves enables and read pointer cleared
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ptrs |=> (rptr == '0 && !ring_en && !irq_en));

    // R8: a lone doorbell loads the masked value
    a_r8_doorbell_load: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && !wr_rptr && !clr_ptrs) |=>
            (rptr == ($past(db_ptr) & $past(ptr_mask))));
endmodule

// File: rtl/ivr_seq.sv
`timescale 1ns/1ps
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18,
    parameter int AW    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_en,
    input  logic              wb_en,
    input  logic              clr,
    input  logic              ovf_clr,
    input  logic [PTR_W-1:0]  ptr_mask,
    input  logic [PTR_W-1:0]  rptr,
    input  logic [AW-9:0]     base,
    input  logic [AW-1:0]     wb_addr,
    input  logic              ev_valid,
    input  ivec_t             ev_vec,
    output logic              ev_ready,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic [PTR_W-1:0]  wptr,
    output logic              ovf,
    output logic              busy
);
    seq_state_t state_q, state_d;
    ivec_t      vec_q;
    logic [PTR_W-1:0] wptr_nx;
    logic [1:0]       word_idx;
    logic             use_wb;
    logic             last_done;
    logic [AW-1:0]    ring_addr;

    assign wptr_nx   = (wptr + PTR_W'(VEC_BYTES)) & ptr_mask;
    assign last_done = (state_q == ST_WORD3) && mem_ready;
    assign ring_addr = {base, 8'h00} + AW'(wptr);
    assign mem_addr  = use_wb ? wb_addr : ring_addr + AW'({word_idx, 2'b00});
    assign busy      = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (ring_en && ev_valid) state_d = ST_WORD0;
            ST_WORD0:     if (mem_ready) state_d = ST_WORD1;
            ST_WORD1:     if (mem_ready) state_d = ST_WORD2;
            ST_WORD2:     if (mem_ready) state_d = ST_WORD3;
            ST_WORD3:     if (mem_ready) state_d = wb_en ? ST_WRITEBACK : ST_IDLE;
            ST_WRITEBACK: if (mem_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    // outputs per state
    always_comb begin
        ev_ready  = 1'b0;
        mem_valid = 1'b0;
        mem_data  = '0;
        word_idx  = 2'd0;
        use_wb    = 1'b0;
        unique case (state_q)
            ST_IDLE: ev_ready = ring_en && !clr;
            ST_WORD0: begin
                mem_valid     = 1'b1;
                word_idx      = 2'd0;
                mem_data[7:0] = vec_q.src;
            end
            ST_WORD1: begin
                mem_valid      = 1'b1;
                word_idx       = 2'd1;
                mem_data[27:0] = vec_q.data;
            end
            ST_WORD2: begin
                mem_valid = 1'b1;
                word_idx  = 2'd2;
                mem_data  = {vec_q.pasid, vec_q.vm, vec_q.ring};
            end
            ST_WORD3: begin
                mem_valid = 1'b1;
                word_idx  = 2'd3;
            end
            ST_WRITEBACK: begin
                mem_valid             = 1'b1;
                use_wb                = 1'b1;
                mem_data[PTR_W-1:0]   = wptr;
                mem_data[CB_OVF]      = ovf;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    vec_q <= '0;
        else if (ev_valid && ev_ready) vec_q <= ev_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            ovf  <= 1'b0;
        end else if (clr) begin
            wptr <= '0;
            ovf  <= 1'b0;
        end else begin
            if (last_done) wptr <= wptr_nx;
            if (last_done && (wptr_nx == rptr)) ovf <= 1'b1;
            else if (ovf_clr)                   ovf <= 1'b0;
        end
    end

    // R11: request held steady under back-pressure
    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !clr) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R3: one vector moves the pointer by 16 within the ring
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (last_done && !clr) |=>
            (wptr == (($past(wptr) + PTR_W'(VEC_BYTES)) & $past(ptr_mask))));

    // R4: overflow flag is sticky
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr && !clr) |=> ovf);

    // R12: an accepted event starts the first word
    a_r12_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> (state_q == ST_WORD0 && mem_valid));
endmodule

// File: rtl/ivr_writer.sv
`timescale 1ns/1ps
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18,
    parameter int AW    = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [7:0]    ev_src,
    input  logic [27:0]   ev_data,
    input  logic [7:0]    ev_ring,
    input  logic [7:0]    ev_vm,
    input  logic [15:0]   ev_pasid,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_data,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          db_valid,
    input  logic [31:0]   db_data,
    output logic          irq
);
    logic             ring_en, irq_en, wb_en, clr_ptrs, ovf_clr, ovf, seq_busy, busy;
    logic [PTR_W-1:0] ptr_mask, rptr, wptr;
    logic [AW-9:0]    base;
    logic [AW-1:0]    wb_addr;
    ivec_t            ev_vec;
    logic             unused_db_bits;

    assign ev_vec         = {ev_pasid, ev_vm, ev_ring, ev_data, ev_src};
    assign busy           = seq_busy | (ev_valid & ring_en);
    assign unused_db_bits = ^db_data[31:PTR_W];
    assign irq            = ring_en & irq_en & ((rptr != wptr) | ovf);

    ivr_regs #(.PTR_W(PTR_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .db_valid  (db_valid),
        .db_ptr    (db_data[PTR_W-1:0]),
        .wptr      (wptr),
        .ovf       (ovf),
        .busy      (busy),
        .ring_en   (ring_en),
        .irq_en    (irq_en),
        .wb_en     (wb_en),
        .ptr_mask  (ptr_mask),
        .rptr      (rptr),
        .base      (base),
        .wb_addr   (wb_addr),
        .clr_ptrs  (clr_ptrs),
        .ovf_clr   (ovf_clr)
    );

    ivr_seq #(.PTR_W(PTR_W), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_en   (ring_en),
        .wb_en     (wb_en),
        .clr       (clr_ptrs),
        .ovf_clr   (ovf_clr),
        .ptr_mask  (ptr_mask),
        .rptr      (rptr),
        .base      (base),
        .wb_addr   (wb_addr),
        .ev_valid  (ev_valid),
        .ev_vec    (ev_vec),
        .ev_ready  (ev_ready),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .wptr      (wptr),
        .ovf       (ovf),
        .busy      (seq_busy)
    );

    // R9: pending entries with both enables raise the line
    a_r9_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_en && irq_en && (rptr != wptr)) |-> irq);

    // R9: no interrupt without both enables
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ring_en && irq_en));
endmodule

// File: tb/tb_ivr_writer.sv
`timescale 1ns/1ps
module tb_ivr_writer;
    localparam int PTR_W = 18;
    localparam int AW    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [7:0]    ev_src = '0;
    logic [27:0]   ev_data = '0;
    logic [7:0]    ev_ring = '0;
    logic [7:0]    ev_vm = '0;
    logic [15:0]   ev_pasid = '0;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_data;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          db_valid = 1'b0;
    logic [31:0]   db_data = '0;
    logic          irq;

    ivr_writer #(.PTR_W(PTR_W), .AW(AW)) dut (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    typedef struct { logic [AW-1:0] a; logic [31:0] d; string tag; } wr_t;
    wr_t exp_q[$];

    logic [PTR_W-1:0] m_wptr = '0, m_rptr = '0, m_mask = '0;
    logic             m_ovf = 1'b0, m_wben = 1'b0;
    logic [31:0]      m_base = '0;
    logic [AW-1:0]    m_wb = '0;
    int               stall_mode = 0;
    int               stall_cnt = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // monitor: drives back-pressure, pops expected writes, checks hold
    logic          pend = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [31:0]   pd = '0;
    always @(negedge clk) begin
        wr_t e;
        if (pend) begin
            check("R11 held valid", 64'(mem_valid), 64'd1);
            check("R11 held addr", 64'(mem_addr), 64'(pa));
            check("R11 held data", 64'(mem_data), 64'(pd));
        end
        stall_cnt++;
        case (stall_mode)
            0:       mem_ready = 1'b1;
            1:       mem_ready = (stall_cnt % 3) != 0;
            default: mem_ready = 1'b0;
        endcase
        if (mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R6/R12 unexpected write actual=%h:%h expected=none", mem_addr, mem_data);
            end else begin
                e = exp_q.pop_front();
                check({e.tag, " addr"}, 64'(mem_addr), 64'(e.a));
                check({e.tag, " data"}, 64'(mem_data), 64'(e.d));
            end
        end
        pend = mem_valid && !mem_ready;
        pa   = mem_addr;
        pd   = mem_data;
    end

    task automatic push(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        wr_t e;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // driver: predicts the writes, then offers the event
    task automatic send(input logic [7:0] s, input logic [27:0] dt, input logic [7:0] rg,
                        input logic [7:0] vm, input logic [15:0] ps);
        logic [PTR_W-1:0] nx;
        logic [AW-1:0]    ra;
        ra = {m_base, 8'h00} + AW'(m_wptr);
        push(ra,      {24'h0, s},      "R2 word0");
        push(ra + 4,  {4'h0, dt},      "R2 word1");
        push(ra + 8,  {ps, vm, rg},    "R2 word2");
        push(ra + 12, 32'h0,           "R2 word3");
        nx = (m_wptr + PTR_W'(16)) & m_mask;
        if (nx == m_rptr) m_ovf = 1'b1;
        m_wptr = nx;
        if (m_wben) push(m_wb, {m_ovf, 31'(m_wptr)}, "R6 writeback");
        @(negedge clk);
        ev_valid = 1'b1; ev_src = s; ev_data = dt; ev_ring = rg; ev_vm = vm; ev_pasid = ps;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        reg_write(3'd0, v);
        m_wben = v[2];
        m_mask = ((PTR_W'(1) << (v[12:8] + 2)) - PTR_W'(1)) & ~PTR_W'(15);
        if (!v[0]) begin m_wptr = '0; m_rptr = '0; m_ovf = 1'b0; end
        if (v[31]) m_ovf = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        check("R1 ev_ready in reset", 64'(ev_ready), 64'd0);
        check("R1 mem_valid in reset", 64'(mem_valid), 64'd0);
        check("R1 irq in reset", 64'(irq), 64'd0);
        rst_n = 1'b1;
        reg_read(3'd0, rd); check("R1 ctrl", 64'(rd), 64'd0);
        reg_read(3'd3, rd); check("R1 wptr", 64'(rd), 64'd0);
        reg_read(3'd2, rd); check("R1 rptr", 64'(rd), 64'd0);

        // configure: 64-word ring (256 bytes)
        m_base = 32'h0012_3400;
        m_wb   = 40'h05_0000_1000;
        reg_write(3'd1, m_base);
        reg_write(3'd4, 32'h0000_1000);
        reg_write(3'd5, 32'h0000_0005);
        set_ctrl(32'h0000_0607);

        stall_mode = 1;
        send(8'h11, 28'hABCDEF1, 8'h01, 8'h02, 16'hBEEF);
        send(8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF);
        send(8'h00, 28'h0000001, 8'h80, 8'h40, 16'h1234);
        drain();
        reg_read(3'd3, rd); check("R3 wptr after three", 64'(rd), 64'h30);
        check("R9 irq with pending", 64'(irq), 64'd1);

        reg_write(3'd2, 32'h30); m_rptr = 'h30;
        check("R9 irq after catch-up", 64'(irq), 64'd0);
        reg_read(3'd2, rd); check("R8 rptr reg write", 64'(rd), 64'h30);

        for (int i = 0; i < 13; i++) send(8'(i), 28'(i * 7), 8'(i), 8'(i + 1), 16'(i * 3));
        drain();
        reg_read(3'd3, rd); check("R3 wrap to zero", 64'(rd), 64'h0);

        // fill to the read pointer
        stall_mode = 0;
        send(8'h21, 28'h1, 8'h0, 8'h0, 16'h0);
        send(8'h22, 28'h2, 8'h0, 8'h0, 16'h0);
        send(8'h23, 28'h3, 8'h0, 8'h0, 16'h0);
        drain();
        reg_read(3'd3, rd); check("R4 overflow set", 64'(rd), 64'h8000_0030);
        check("R9 irq on overflow with equal pointers", 64'(irq), 64'd1);
        send(8'h24, 28'h4, 8'h0, 8'h0, 16'h0);
        drain();
        reg_read(3'd3, rd); check("R4 overflow sticky", 64'(rd), 64'h8000_0040);

        set_ctrl(32'h8000_0607);
        reg_read(3'd3, rd); check("R5 overflow cleared", 64'(rd), 64'h40);
        reg_read(3'd0, rd); check("R5 ctrl bit31 reads zero", 64'(rd), 64'h0607);

        // doorbell and priority
        @(negedge clk); db_valid = 1'b1; db_data = 32'h1234_5678;
        @(negedge clk); db_valid = 1'b0;
        reg_read(3'd2, rd); check("R8 doorbell masked", 64'(rd), 64'h70);
        @(negedge clk);
        db_valid = 1'b1; db_data = 32'h40;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h20;
        @(negedge clk); db_valid = 1'b0; reg_wr = 1'b0;
        m_rptr = 'h20;
        reg_read(3'd2, rd); check("R8 register beats doorbell", 64'(rd), 64'h20);

        // no writeback
        set_ctrl(32'h0000_0603);
        stall_mode = 1;
        send(8'h31, 28'h5, 8'h6, 8'h7, 16'h8);
        drain();
        reg_read(3'd3, rd); check("R6 no writeback wptr", 64'(rd), 64'h50);

        // busy while stalled
        stall_mode = 2;
        send(8'h41, 28'h9, 8'h1, 8'h1, 16'h1);
        reg_read(3'd0, rd); check("R10 busy in flight", 64'(rd), 64'h0001_0603);
        stall_mode = 0;
        drain();
        reg_read(3'd0, rd); check("R10 idle", 64'(rd), 64'h0603);

        // disable
        set_ctrl(32'h0000_0000);
        reg_read(3'd3, rd); check("R7 wptr cleared", 64'(rd), 64'h0);
        reg_read(3'd2, rd); check("R7 rptr cleared", 64'(rd), 64'h0);
        reg_read(3'd0, rd); check("R7 ctrl cleared", 64'(rd), 64'h0);
        check("R7 irq low", 64'(irq), 64'd0);

        @(negedge clk); ev_valid = 1'b1;
        repeat (10) @(negedge clk);
        check("R12 ev_ready low when disabled", 64'(ev_ready), 64'd0);
        check("R12 no write when disabled", 64'(mem_valid), 64'd0);
        ev_valid = 1'b0;

        set_ctrl(32'h0000_0607);
        send(8'h51, 28'h0AA, 8'h2, 8'h3, 16'h4);
        drain();
        reg_read(3'd3, rd); check("R7 restart from zero", 64'(rd), 64'h10);
        check("R2 all expected writes seen", 64'(exp_q.size()), 64'd0);

        finish_run();
    end
endmodule